// File: doc/BRIEF.md
# SPI FIFO Event and Mask Unit

This block sits between a 32-bit register port and an SPI shift engine. It holds one byte FIFO per direction, 32 bytes deep by default. Software fills the transmit side a whole word at a time and drains the receive side either as whole words or as single bytes, so a message whose length is not a multiple of four can still be emptied cleanly. The shift engine pulls transmit bytes and pushes receive bytes one at a time through a simple valid/pop and push/space interface.

A 32-bit event word combines the live byte counts of both FIFOs with a set of status flags. Four level flags follow FIFO occupancy and two programmable thresholds held in a mode register. Two sticky error flags record a transmit write that did not fit and a receive read that found too few bytes. A mask register uses the same bit positions as the flags, and the interrupt output is high whenever any flag is set while its mask bit is also set.

Top module: `spi_fifo_evt`

## Requirements
- R1: While reset is held and until the first clock edge after it, the event word and mask read 0, `irq` is low, and the mode register (address 0) reads 0x0000_0403 (transmit threshold 4 in bits 13:8, receive threshold 3 in bits 5:0). One edge after reset is released, the event word reads 0x0000_0900.
- R2: Event word (address 1) bits 29:24 carry the receive FIFO byte count and bits 21:16 the transmit FIFO byte count. Both fields are live: they are correct right after the edge that changes the count.
- R3: A write to the transmit port (address 3) pushes four bytes, bits 31:24 first and bits 7:0 last. The engine sees them in that order on `engTxByte`.
- R4: A transmit port write when fewer than four bytes are free pushes nothing and sets sticky flag bit 4.
- R5: A word read of the receive port (address 4, `cfgByte`=0) returns the four oldest bytes, oldest in bits 31:24, and pops four. A byte read (`cfgByte`=1) returns the oldest byte in bits 7:0 with the upper bits zero, and pops one.
- R6: A word read with fewer than four bytes stored, or a byte read of an empty FIFO, returns 0, pops nothing and sets sticky flag bit 3.
- R7: Level flags are registered one cycle behind occupancy. Bit 9 is set when the receive FIFO is not empty. Bit 8 is set when the transmit FIFO is not full. Bit 13 is set when the receive count exceeds the receive threshold. Bit 11 is set when the transmit count is at or below the transmit threshold.
- R8: Writing a 1 to a flag bit of the event word clears it, and 0 bits leave flags alone. A sticky flag then stays clear until its error recurs. A level flag reads 0 for one cycle and then sets again if its condition still holds.
- R9: The mask register (address 2) stores only the six flag positions. `irq` is the OR of the flags ANDed with the mask.
- R10: Writing the mode register changes the thresholds, and the threshold flags follow the new values.
- R11: An engine push into a full receive FIFO is dropped, and `engRxSpace` is low in that case. An engine pop from an empty transmit FIFO is ignored, and `engTxValid` is low in that case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgRe | input | 1 | Register read strobe (pops on receive port) |
| cfgByte | input | 1 | Receive port access is a single byte |
| cfgAddr | input | 3 | Register select: 0 mode, 1 event, 2 mask, 3 transmit port, 4 receive port |
| cfgWdata | input | 32 | Write data |
| cfgRdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt, any unmasked flag set |
| engTxPop | input | 1 | Engine takes one transmit byte |
| engTxValid | output | 1 | Transmit FIFO holds a byte |
| engTxByte | output | 8 | Oldest transmit byte |
| engRxPush | input | 1 | Engine delivers one receive byte |
| engRxByte | input | 8 | Received byte |
| engRxSpace | output | 1 | Receive FIFO can accept a byte |

## Verification
The bench goes after the fill edges. A transmit write with exactly four bytes free must be accepted, and the next one must be refused. A design that got the room check wrong would either wrap its pointers and corrupt queued bytes or raise the overrun flag early. On the receive side it reads words with two or three bytes stored and bytes from an empty FIFO: a faulty design would pop stale data or fail to flag the underrun. It also clears a level flag whose condition still holds and samples in both the cleared cycle and the following one. A design that made level flags sticky, or that ignored the clear, shows the wrong bit 9 in one of those two samples. Byte order on both ports and the one-cycle flag lag are checked against a queue model under random traffic, thresholds and masks.

// File: rtl/spi_fifo_evt_pkg.sv
package spi_fifo_evt_pkg;

  localparam int WORD_BYTES = 4;
  localparam int THR_W      = 6;
  localparam int CNT_FLD_W  = 6;

  // event word field positions
  localparam int EVT_RXCNT_LSB = 24;
  localparam int EVT_TXCNT_LSB = 16;

  // flag positions (shared by event and mask)
  localparam int FLG_RXTHR = 13;
  localparam int FLG_TXTHR = 11;
  localparam int FLG_RXNE  = 9;
  localparam int FLG_TXNF  = 8;
  localparam int FLG_TXOVR = 4;
  localparam int FLG_RXUND = 3;

  localparam logic [31:0] LEVEL_BITS  = (32'd1 << FLG_RXTHR) | (32'd1 << FLG_TXTHR)
                                      | (32'd1 << FLG_RXNE)  | (32'd1 << FLG_TXNF);
  localparam logic [31:0] STICKY_BITS = (32'd1 << FLG_TXOVR) | (32'd1 << FLG_RXUND);
  localparam logic [31:0] FLAG_BITS   = LEVEL_BITS | STICKY_BITS;

  localparam logic [THR_W-1:0] TX_THR_RST = 6'd4;
  localparam logic [THR_W-1:0] RX_THR_RST = 6'd3;

  typedef enum logic [2:0] {
    REG_MODE   = 3'd0,
    REG_EVENT  = 3'd1,
    REG_MASK   = 3'd2,
    REG_TXPORT = 3'd3,
    REG_RXPORT = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic txPushWord;
    logic rxPopWord;
    logic rxPopByte;
  } fifoStrobe_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH      = 32,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES  = 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int PSW = $clog2(PUSH_LANES + 1),
  localparam int PPW = $clog2(POP_LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [PSW-1:0]          pushCnt,
  input  logic [8*PUSH_LANES-1:0] pushData,
  input  logic [PPW-1:0]          popCnt,
  output logic [CW-1:0]           count,
  output logic [8*POP_LANES-1:0]  peek
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;
  logic [AW-1:0] wrIdx [PUSH_LANES];
  logic [AW-1:0] rdIdx [POP_LANES];

  // lane 0 is the most significant byte and goes in first
  for (genvar g = 0; g < PUSH_LANES; g++) begin : gWrIdx
    assign wrIdx[g] = wrPtr + AW'(g);
  end

  for (genvar g = 0; g < POP_LANES; g++) begin : gPeek
    assign rdIdx[g] = rdPtr + AW'(g);
    assign peek[8*(POP_LANES-1-g) +: 8] = mem[rdIdx[g]];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_LANES; i++) begin
      if (i < int'(pushCnt)) mem[wrIdx[i]] <= pushData[8*(PUSH_LANES-1-i) +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushCnt);
      rdPtr <= rdPtr + AW'(popCnt);
      count <= count + CW'(pushCnt) - CW'(popCnt);
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) <= DEPTH);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    int'(count) + int'(pushCnt) <= DEPTH);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(popCnt) <= int'(count));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushCnt == '0 && popCnt == '0) |=> $stable(count));

endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fifoStrobe_t             strobe,
  input  logic [8*WORD_BYTES-1:0] txWord,
  input  logic                    engTxPop,
  input  logic                    engRxPush,
  input  logic [7:0]              engRxByte,
  output logic                    engTxValid,
  output logic [7:0]              engTxByte,
  output logic                    engRxSpace,
  output logic [CW-1:0]           txCount,
  output logic [CW-1:0]           rxCount,
  output logic [8*WORD_BYTES-1:0] rxPeek
);

  localparam int WSW = $clog2(WORD_BYTES + 1);

  logic [WSW-1:0] txPushCnt;
  logic [0:0]     txPopCnt;
  logic [0:0]     rxPushCnt;
  logic [WSW-1:0] rxPopCnt;

  assign engTxValid = (txCount != '0);
  assign engRxSpace = (rxCount != CW'(DEPTH));

  assign txPushCnt = strobe.txPushWord ? WSW'(WORD_BYTES) : '0;
  assign txPopCnt  = engTxPop && engTxValid;
  assign rxPushCnt = engRxPush && engRxSpace;
  assign rxPopCnt  = strobe.rxPopWord ? WSW'(WORD_BYTES)
                   : (strobe.rxPopByte ? WSW'(1) : '0);

  spi_byte_fifo #(
    .DEPTH(DEPTH), .PUSH_LANES(WORD_BYTES), .POP_LANES(1)
  ) uTxFifo (
    .clk(clk), .rstN(rstN),
    .pushCnt(txPushCnt), .pushData(txWord),
    .popCnt(txPopCnt), .count(txCount), .peek(engTxByte)
  );

  spi_byte_fifo #(
    .DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(WORD_BYTES)
  ) uRxFifo (
    .clk(clk), .rstN(rstN),
    .pushCnt(rxPushCnt), .pushData(engRxByte),
    .popCnt(rxPopCnt), .count(rxCount), .peek(rxPeek)
  );

  assert_full_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && !engRxSpace && rxPopCnt == '0) |=> $stable(rxCount));

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && !engTxValid && txPushCnt == '0) |=> (txCount == '0));

endmodule

// File: rtl/spi_evt_ctrl.sv
module spi_evt_ctrl
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic                    cfgRe,
  input  logic                    cfgByte,
  input  logic [2:0]              cfgAddr,
  input  logic [31:0]             cfgWdata,
  output logic [31:0]             cfgRdata,
  output logic                    irq,
  input  logic [CW-1:0]           txCount,
  input  logic [CW-1:0]           rxCount,
  input  logic [8*WORD_BYTES-1:0] rxPeek,
  output fifoStrobe_t             strobe
);

  regSel_e          sel;
  logic [THR_W-1:0] txThr;
  logic [THR_W-1:0] rxThr;
  logic [31:0]      maskQ;
  logic [31:0]      flagQ;
  logic [31:0]      flagD;
  logic [31:0]      condVec;
  logic [31:0]      setVec;
  logic [31:0]      clrVec;
  logic [31:0]      evtWord;
  logic             txRoom;
  logic             rxOk;
  logic             wrTx;
  logic             rdRx;
  logic             wrEvt;

  assign sel   = regSel_e'(cfgAddr);
  assign wrTx  = cfgWe && (sel == REG_TXPORT);
  assign rdRx  = cfgRe && (sel == REG_RXPORT);
  assign wrEvt = cfgWe && (sel == REG_EVENT);

  // room and data checks use the occupancy before this cycle's engine traffic
  assign txRoom = int'(txCount) <= DEPTH - WORD_BYTES;
  assign rxOk   = cfgByte ? (rxCount != '0) : (int'(rxCount) >= WORD_BYTES);

  assign strobe.txPushWord = wrTx && txRoom;
  assign strobe.rxPopWord  = rdRx && rxOk && !cfgByte;
  assign strobe.rxPopByte  = rdRx && rxOk && cfgByte;

  always_comb begin
    condVec            = '0;
    condVec[FLG_RXTHR] = int'(rxCount) > int'(rxThr);
    condVec[FLG_TXTHR] = int'(txCount) <= int'(txThr);
    condVec[FLG_RXNE]  = (rxCount != '0);
    condVec[FLG_TXNF]  = (txCount != CW'(DEPTH));

    setVec             = '0;
    setVec[FLG_TXOVR]  = wrTx && !txRoom;
    setVec[FLG_RXUND]  = rdRx && !rxOk;

    clrVec = wrEvt ? (cfgWdata & FLAG_BITS) : '0;

    flagD = (condVec & ~clrVec & LEVEL_BITS)
          | (((flagQ & ~clrVec) | setVec) & STICKY_BITS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      maskQ <= '0;
      txThr <= TX_THR_RST;
      rxThr <= RX_THR_RST;
    end else begin
      flagQ <= flagD;
      if (cfgWe && sel == REG_MASK) maskQ <= cfgWdata & FLAG_BITS;
      if (cfgWe && sel == REG_MODE) begin
        txThr <= cfgWdata[8 +: THR_W];
        rxThr <= cfgWdata[0 +: THR_W];
      end
    end
  end

  assign irq = |(flagQ & maskQ);

  always_comb begin
    evtWord = flagQ;
    evtWord[EVT_RXCNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(rxCount);
    evtWord[EVT_TXCNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(txCount);
  end

  always_comb begin
    unique case (sel)
      REG_MODE:   cfgRdata = {18'd0, txThr, 2'd0, rxThr};
      REG_EVENT:  cfgRdata = evtWord;
      REG_MASK:   cfgRdata = maskQ;
      REG_RXPORT: cfgRdata = !rxOk ? 32'd0
                           : (cfgByte ? {24'd0, rxPeek[31:24]} : rxPeek);
      default:    cfgRdata = 32'd0;
    endcase
  end

  assert_tx_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && int'(txCount) > DEPTH - WORD_BYTES) |=> flagQ[FLG_TXOVR]);

  assert_rx_underrun_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdRx && rxCount == '0) |=> flagQ[FLG_RXUND]);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ[FLG_TXOVR] && !(wrEvt && cfgWdata[FLG_TXOVR])) |=> flagQ[FLG_TXOVR]);

  assert_level_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvt && cfgWdata[FLG_RXNE]) |=> !flagQ[FLG_RXNE]);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irq);

endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
  import spi_fifo_evt_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic        cfgRe,
  input  logic        cfgByte,
  input  logic [2:0]  cfgAddr,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  output logic        irq,
  input  logic        engTxPop,
  output logic        engTxValid,
  output logic [7:0]  engTxByte,
  input  logic        engRxPush,
  input  logic [7:0]  engRxByte,
  output logic        engRxSpace
);

  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobe_t             strobe;
  logic [CW-1:0]           txCount;
  logic [CW-1:0]           rxCount;
  logic [8*WORD_BYTES-1:0] rxPeek;

  spi_evt_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgRe(cfgRe), .cfgByte(cfgByte),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .irq(irq),
    .txCount(txCount), .rxCount(rxCount), .rxPeek(rxPeek),
    .strobe(strobe)
  );

  spi_fifo_dp #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .txWord(cfgWdata),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engRxByte(engRxByte),
    .engTxValid(engTxValid), .engTxByte(engTxByte), .engRxSpace(engRxSpace),
    .txCount(txCount), .rxCount(rxCount), .rxPeek(rxPeek)
  );

endmodule

// File: tb/spi_fifo_evt_test.sv
module spi_fifo_evt_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgRe = 1'b0, cfgByte = 1'b0;
  logic [2:0]  cfgAddr = 3'd0;
  logic [31:0] cfgWdata = 32'd0;
  logic [31:0] cfgRdata;
  logic        irq;
  logic        engTxPop = 1'b0;
  logic        engTxValid;
  logic [7:0]  engTxByte;
  logic        engRxPush = 1'b0;
  logic [7:0]  engRxByte = 8'd0;
  logic        engRxSpace;

  spi_fifo_evt #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgRe(cfgRe), .cfgByte(cfgByte), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .irq(irq),
    .engTxPop(engTxPop), .engTxValid(engTxValid), .engTxByte(engTxByte),
    .engRxPush(engRxPush), .engRxByte(engRxByte), .engRxSpace(engRxSpace)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // reference model
  logic [7:0]  txQ[$];
  logic [7:0]  rxQ[$];
  bit          stOvr = 0, stUnd = 0;
  int          txThr = 4, rxThr = 3;
  logic [31:0] maskM = 32'd0;

  function automatic logic [31:0] expEvent();
    logic [31:0] e = 32'd0;
    e[29:24] = 6'(rxQ.size());
    e[21:16] = 6'(txQ.size());
    e[13] = rxQ.size() > rxThr;
    e[11] = txQ.size() <= txThr;
    e[9]  = rxQ.size() != 0;
    e[8]  = txQ.size() != DEPTH;
    e[4]  = stOvr;
    e[3]  = stUnd;
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peekReg(logic [2:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdata;
  endtask

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfgAddr = a; cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic txWrite(logic [31:0] w);
    if (txQ.size() <= DEPTH - 4) begin
      for (int i = 3; i >= 0; i--) txQ.push_back(w[8*i +: 8]);
    end else stOvr = 1;
    busWrite(3'd3, w);
  endtask

  task automatic rxRead(bit isByte, string tag);
    logic [31:0] exp = 32'd0;
    if (isByte) begin
      if (rxQ.size() >= 1) exp = {24'd0, rxQ.pop_front()};
      else stUnd = 1;
    end else begin
      if (rxQ.size() >= 4)
        for (int i = 0; i < 4; i++) exp = {exp[23:0], rxQ.pop_front()};
      else stUnd = 1;
    end
    @(negedge clk);
    cfgAddr = 3'd4; cfgByte = isByte; cfgRe = 1'b1;
    #1;
    chk(tag, cfgRdata, exp);
    @(negedge clk);
    cfgRe = 1'b0; cfgByte = 1'b0;
  endtask

  task automatic engPop();
    @(negedge clk);
    chk("R11 engTxValid", {31'd0, engTxValid}, {31'd0, txQ.size() != 0});
    if (txQ.size() != 0) chk("R3 engTxByte order", {24'd0, engTxByte}, {24'd0, txQ.pop_front()});
    engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic engPush(logic [7:0] b);
    @(negedge clk);
    chk("R11 engRxSpace", {31'd0, engRxSpace}, {31'd0, rxQ.size() < DEPTH});
    if (rxQ.size() < DEPTH) rxQ.push_back(b);
    engRxPush = 1'b1; engRxByte = b;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic clearEvt(logic [31:0] v);
    if (v[4]) stOvr = 0;
    if (v[3]) stUnd = 0;
    busWrite(3'd1, v);
  endtask

  task automatic setMask(logic [31:0] m);
    maskM = m & 32'h0000_2B18;
    busWrite(3'd2, m);
  endtask

  task automatic setMode(int tx, int rx);
    txThr = tx; rxThr = rx;
    busWrite(3'd0, (32'(tx) << 8) | 32'(rx));
  endtask

  // one idle edge lets the level flags catch up, then compare everything
  task automatic settle(string tag);
    logic [31:0] ev;
    @(negedge clk);
    peekReg(3'd1, ev);
    chk({tag, " event"}, ev, expEvent());
    chk("R9 irq", {31'd0, irq}, {31'd0, |(expEvent() & maskM)});
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));

    // R1 reset state
    repeat (3) @(negedge clk);
    peekReg(3'd1, d); chk("R1 event in reset", d, 32'd0);
    peekReg(3'd2, d); chk("R1 mask in reset", d, 32'd0);
    peekReg(3'd0, d); chk("R1 mode in reset", d, 32'h0000_0403);
    chk("R1 irq in reset", {31'd0, irq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    peekReg(3'd1, d); chk("R1 event after reset", d, 32'h0000_0900);

    // R3 byte order, R2 live count
    txWrite(32'hA1B2C3D4);
    peekReg(3'd1, d); chk("R2 tx count live", {26'd0, d[21:16]}, 32'd4);
    settle("R7");
    for (int i = 0; i < 4; i++) engPop();
    settle("R3");
    engPop(); // R11 empty pop
    settle("R11 empty pop");

    // R4 fill edge
    for (int i = 0; i < 8; i++) txWrite(32'h1000_0000 + 32'(i));
    settle("R7 tx full");
    txWrite(32'hDEAD_BEEF);
    settle("R4 overrun");
    peekReg(3'd1, d); chk("R4 tx count held", {26'd0, d[21:16]}, 32'd32);
    setMask(32'h10);
    settle("R9 sticky irq");
    clearEvt(32'h10);
    settle("R8 sticky clear");
    for (int i = 0; i < 32; i++) engPop();
    settle("R3 drain");

    // R5 / R6 receive side
    for (int i = 0; i < 5; i++) engPush(8'h11 + 8'(i));
    peekReg(3'd1, d); chk("R2 rx count live", {26'd0, d[29:24]}, 32'd5);
    rxRead(0, "R5 word read");
    rxRead(1, "R5 byte read");
    rxRead(1, "R6 byte read empty");
    settle("R6 underrun");
    engPush(8'h77); engPush(8'h88);
    rxRead(0, "R6 word read short");
    settle("R6 no pop");

    // R8 level flag reassert
    clearEvt(32'h200);
    peekReg(3'd1, d); chk("R8 level cleared", {31'd0, d[9]}, 32'd0);
    settle("R8 level reasserts");

    // R9 mask, R10 thresholds
    setMask(32'h200);
    settle("R9 mask ne");
    setMask(32'h0);
    settle("R9 mask off");
    setMode(4, 1);
    peekReg(3'd0, d); chk("R10 mode readback", d, 32'h0000_0401);
    settle("R10 rx thr low");
    setMode(0, 5);
    settle("R10 thr high");
    rxRead(1, "R5 byte"); rxRead(1, "R5 byte");
    clearEvt(32'h18);
    setMode(4, 3);

    // R11 full receive FIFO
    for (int i = 0; i < 33; i++) engPush(8'(i * 7));
    settle("R11 rx full");
    for (int i = 0; i < 8; i++) rxRead(0, "R5 drain word");
    settle("R5 drained");

    // random phase
    for (int it = 0; it < 500; it++) begin
      int r = int'($urandom % 10);
      case (r)
        0, 1: txWrite($urandom);
        2, 3: engPop();
        4, 5: engPush(8'($urandom));
        6:    rxRead(0, "R5 random word");
        7:    rxRead(1, "R5 random byte");
        8:    clearEvt($urandom & 32'h0000_2B18);
        default: begin
          if ($urandom % 2 == 0) setMask($urandom);
          else setMode(int'($urandom % 34), int'($urandom % 34));
        end
      endcase
      settle("R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule